// File: doc/BRIEF.md
# Host Command Port with Read-Data Hold

This block lets a host processor drive single transactions into a serial peripheral bridge through a small set of registers. The host writes an optional data word and then a command word. The command word carries a direction flag and a target address. Writing the command word starts the transaction. A four-state sequencer presents the request on a generic request/acknowledge port toward the bridge.

Write transactions go back to idle as soon as the bridge acknowledges them. Read transactions first wait for the bridge to return data. The sequencer then parks with that data held in a read-data register. It leaves that state only when the host writes 1 to a release register. The host polls a status register, which shows the sequencer state, a read-valid flag and a sticky error flag for rejected commands. A separate register shows bit 0 = initialised, which is set from an input pin.

Top module: `swcmd_port`

## Requirements
- R1: After synchronous active-low reset, the status register reads 0 and the read-data register reads 0. The ready register reads 0 and the downstream request is low.
- R2: Bit 0 of the ready register (select 5) stays 0 until the `init_done_i` input is seen high. From then on it reads 1 until the next reset, even after the input falls.
- R3: A write to the command register (select 0) while idle moves the status state field (bits [3:1]) to 1 on the next cycle. In that cycle `dn_req` is high and `dn_addr` equals command bits [15:0]. `dn_write` equals command bit 29, and `dn_wdata` equals the value last written to the write-data register (select 1). These outputs stay stable until `dn_ack`.
- R4: With bit 29 = 1, a `dn_ack` in state 1 returns the state field to 0 on the next cycle, and `dn_req` drops.
- R5: With bit 29 = 0, a `dn_ack` in state 1 moves the state field to 2. The block stays in state 2 until `dn_rvalid`. It then captures `dn_rdata` into the read-data register (select 2), moves to state 3 and sets status bit 0.
- R6: In state 3 the read-data register keeps the captured value while `dn_rdata` changes. After release it keeps that value until the next read captures new data.
- R7: A write of a value with bit 0 = 1 to the release register (select 3) in state 3 returns the state to 0 and clears status bit 0. A write with bit 0 = 0 has no effect.
- R8: A release write in states 0, 1 or 2 has no effect on the state or the read data.
- R9: A command write outside state 0 is ignored: the state and the downstream address and direction do not change. It also sets status bit 4, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done_i | input | 1 | Marks the bridge as initialised |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read value of the selected register |
| dn_req | output | 1 | Downstream request, held high in state 1 |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 16 | Downstream target address |
| dn_wdata | output | 16 | Downstream write data |
| dn_ack | input | 1 | Downstream acceptance pulse |
| dn_rvalid | input | 1 | Downstream read-data strobe |
| dn_rdata | input | 16 | Downstream read data |

## Verification
The bench sweeps addresses, data patterns and response latencies across both directions. It goes after read data that could be overwritten. A design that sampled `dn_rdata` after the capture cycle would report junk that the bench drives after the strobe. A release write with bit 0 clear, or any release outside the hold state, must leave the sequencer unchanged. A design that decoded the release too loosely would jump to idle and lose a pending read. A command written while busy must neither redirect the in-flight request nor go unrecorded. The bench therefore checks that the downstream address is unchanged and that the sticky error bit is set.

// File: rtl/swcmd_pkg.sv
// Shared definitions for the host command port.
// Assumes: register selects and status bit positions below are the host-visible map.
package swcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_AWAIT = 3'd2,
        ST_HOLD  = 3'd3
    } swcmd_state_e;

    localparam int REG_CMD  = 0;
    localparam int REG_WDAT = 1;
    localparam int REG_RDAT = 2;
    localparam int REG_CLR  = 3;
    localparam int REG_STAT = 4;
    localparam int REG_INIT = 5;

    localparam int STAT_VALID_BIT = 0;
    localparam int STAT_STATE_LSB = 1;
    localparam int STAT_ERR_BIT   = 4;

endpackage

// File: rtl/swcmd_regs.sv
// Host register file: decodes write strobes and holds the write-data word,
// the ready flag and the sticky error flag. Builds the read mux.
// Assumes: host_rdata is combinational on host_sel; the sequencer owns read data.
module swcmd_regs
    import swcmd_pkg::*;
#(
    parameter int HOST_AW = 3,
    parameter int HOST_DW = 32,
    parameter int DW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_done_i,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_sel,
    input  logic [HOST_DW-1:0] host_wdata,
    input  swcmd_state_e       state,
    input  logic [DW-1:0]      rd_hold,
    input  logic               cmd_reject,
    output logic               cmd_wr,
    output logic               clr_wr,
    output logic [DW-1:0]      wdata_q,
    output logic               init_q,
    output logic               err_q,
    output logic [HOST_DW-1:0] host_rdata
);

    localparam logic [HOST_AW-1:0] SEL_CMD  = HOST_AW'(REG_CMD);
    localparam logic [HOST_AW-1:0] SEL_WDAT = HOST_AW'(REG_WDAT);
    localparam logic [HOST_AW-1:0] SEL_RDAT = HOST_AW'(REG_RDAT);
    localparam logic [HOST_AW-1:0] SEL_CLR  = HOST_AW'(REG_CLR);
    localparam logic [HOST_AW-1:0] SEL_STAT = HOST_AW'(REG_STAT);
    localparam logic [HOST_AW-1:0] SEL_INIT = HOST_AW'(REG_INIT);

    // Decode the write strobes toward the sequencer.
    always_comb begin
        cmd_wr = host_wr && (host_sel == SEL_CMD);
        clr_wr = host_wr && (host_sel == SEL_CLR) && host_wdata[0];
    end

    // Hold the write-data word for the next command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (host_wr && (host_sel == SEL_WDAT)) begin
            wdata_q <= host_wdata[DW-1:0];
        end
    end

    // Sticky ready flag and sticky rejected-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (init_done_i) init_q <= 1'b1;
            if (cmd_reject)  err_q  <= 1'b1;
        end
    end

    // Read mux over the host-visible registers.
    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_WDAT: host_rdata[DW-1:0] = wdata_q;
            SEL_RDAT: host_rdata[DW-1:0] = rd_hold;
            SEL_STAT: begin
                host_rdata[STAT_VALID_BIT]                   = (state == ST_HOLD);
                host_rdata[STAT_STATE_LSB+2:STAT_STATE_LSB] = state;
                host_rdata[STAT_ERR_BIT]                     = err_q;
            end
            SEL_INIT: host_rdata[0] = init_q;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/swcmd_fsm.sv
// Transaction sequencer: latches a command in idle, requests downstream,
// waits for read data and holds it until the host releases it.
// Assumes: dn_ack is a one-cycle pulse in ISSUE; read data comes later with dn_rvalid.
module swcmd_fsm
    import swcmd_pkg::*;
#(
    parameter int HOST_DW   = 32,
    parameter int DW        = 16,
    parameter int TAW       = 16,
    parameter int WFLAG_BIT = 29
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [HOST_DW-1:0] cmd_word,
    input  logic               clr_wr,
    input  logic [DW-1:0]      wdata_q,
    input  logic               dn_ack,
    input  logic               dn_rvalid,
    input  logic [DW-1:0]      dn_rdata,
    output swcmd_state_e       state,
    output logic               dn_req,
    output logic               dn_write,
    output logic [TAW-1:0]     dn_addr,
    output logic [DW-1:0]      dn_wdata,
    output logic [DW-1:0]      rd_hold,
    output logic               cmd_reject
);

    // State register and per-transaction latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dn_addr  <= '0;
            dn_write <= 1'b0;
            dn_wdata <= '0;
            rd_hold  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_wr) begin
                    state    <= ST_ISSUE;
                    dn_addr  <= cmd_word[TAW-1:0];
                    dn_write <= cmd_word[WFLAG_BIT];
                    dn_wdata <= wdata_q;
                end
                ST_ISSUE: if (dn_ack) begin
                    state <= dn_write ? ST_IDLE : ST_AWAIT;
                end
                ST_AWAIT: if (dn_rvalid) begin
                    rd_hold <= dn_rdata;
                    state   <= ST_HOLD;
                end
                ST_HOLD: if (clr_wr) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request level and rejected-command pulse.
    always_comb begin
        dn_req     = (state == ST_ISSUE);
        cmd_reject = cmd_wr && (state != ST_IDLE);
    end

endmodule

// File: rtl/swcmd_port.sv
// Top of the host command port: register file plus transaction sequencer.
// Assumes: one host register access per cycle; downstream follows req/ack/rvalid.
module swcmd_port
    import swcmd_pkg::*;
#(
    parameter int HOST_AW   = 3,
    parameter int HOST_DW   = 32,
    parameter int DW        = 16,
    parameter int TAW       = 16,
    parameter int WFLAG_BIT = 29
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_done_i,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_sel,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               dn_req,
    output logic               dn_write,
    output logic [TAW-1:0]     dn_addr,
    output logic [DW-1:0]      dn_wdata,
    input  logic               dn_ack,
    input  logic               dn_rvalid,
    input  logic [DW-1:0]      dn_rdata
);

    swcmd_state_e  state;
    logic [2:0]    st_code;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rd_hold;
    logic          cmd_wr;
    logic          clr_wr;
    logic          cmd_reject;
    logic          init_q;
    logic          err_q;

    assign st_code = state;

    swcmd_regs #(
        .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .DW(DW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .state(state), .rd_hold(rd_hold), .cmd_reject(cmd_reject),
        .cmd_wr(cmd_wr), .clr_wr(clr_wr), .wdata_q(wdata_q),
        .init_q(init_q), .err_q(err_q), .host_rdata(host_rdata)
    );

    swcmd_fsm #(
        .HOST_DW(HOST_DW), .DW(DW), .TAW(TAW), .WFLAG_BIT(WFLAG_BIT)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(host_wdata),
        .clr_wr(clr_wr), .wdata_q(wdata_q), .dn_ack(dn_ack),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .state(state),
        .dn_req(dn_req), .dn_write(dn_write), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .rd_hold(rd_hold), .cmd_reject(cmd_reject)
    );

endmodule

// File: rtl/swcmd_port_chk.sv
// Protocol checker for swcmd_port, attached by bind below.
// Assumes: state codes 0..3 as in the status field; release select 3.
module swcmd_port_chk #(
    parameter int HOST_AW = 3,
    parameter int HOST_DW = 32,
    parameter int DW      = 16,
    parameter int TAW     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_sel,
    input logic [HOST_DW-1:0] host_wdata,
    input logic               dn_req,
    input logic               dn_ack,
    input logic               dn_write,
    input logic [TAW-1:0]     dn_addr,
    input logic [2:0]         st_code,
    input logic [DW-1:0]      rd_hold,
    input logic               init_q,
    input logic               err_q
);

    localparam logic [HOST_AW-1:0] SEL_CLR = HOST_AW'(swcmd_pkg::REG_CLR);

    logic rel_wr;
    assign rel_wr = host_wr && (host_sel == SEL_CLR) && host_wdata[0];

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_write))); // R3
    AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd1 && dn_ack && dn_write) |=> (st_code == 3'd0 && !dn_req)); // R4
    AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd1 && dn_ack && !dn_write) |=> (st_code == 3'd2)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd3) |=> $stable(rd_hold)); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd3 && rel_wr) |=> (st_code == 3'd0)); // R7
    AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd3 && !rel_wr) |=> (st_code == 3'd3)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> init_q); // R2

endmodule

bind swcmd_port swcmd_port_chk #(
    .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .DW(DW), .TAW(TAW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .dn_req(dn_req), .dn_ack(dn_ack),
    .dn_write(dn_write), .dn_addr(dn_addr), .st_code(st_code),
    .rd_hold(rd_hold), .init_q(init_q), .err_q(err_q)
);

// File: tb/swcmd_port_tb.sv
module swcmd_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done_i = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dn_req, dn_write;
    logic [15:0] dn_addr, dn_wdata;
    logic        dn_ack = 1'b0;
    logic        dn_rvalid = 1'b0;
    logic [15:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    swcmd_port dut_i (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dn_req(dn_req), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
        host_sel = sel;
        #0.5;
        val = host_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] stat(input int st, input bit err);
        return {27'd0, err, 3'(st), (st == 3)};
    endfunction

    logic [31:0] v;
    bit          err_exp;
    logic [15:0] last_rd;

    initial begin
        repeat (3) tick();
        rd_reg(3'd4, v); chk("R1 status", v, 32'd0);
        rd_reg(3'd2, v); chk("R1 rdata", v, 32'd0);
        rd_reg(3'd5, v); chk("R1 ready", v, 32'd0);
        chk("R1 req", {31'd0, dn_req}, 32'd0);
        rst_n = 1'b1;
        tick();
        rd_reg(3'd5, v); chk("R2 ready before", v, 32'd0);
        init_done_i = 1'b1; tick(); init_done_i = 1'b0; tick();
        rd_reg(3'd5, v); chk("R2 ready sticky", v, 32'd1);

        // R8: release while idle
        wr_reg(3'd3, 32'd1);
        rd_reg(3'd4, v); chk("R8 release idle", v, stat(0, 0));

        err_exp = 0;
        last_rd = '0;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] a, d;
            bit is_wr;
            a = 16'(i * 16'h1357 + 3);
            d = 16'(i * 16'h2b1 ^ 16'ha5a5);
            is_wr = i[0];
            wr_reg(3'd1, {16'hffff, d});
            wr_reg(3'd0, {2'b0, is_wr, 13'h1fff, a});
            rd_reg(3'd4, v); chk("R3 state issue", v, stat(1, err_exp));
            chk("R3 req", {31'd0, dn_req}, 32'd1);
            chk("R3 addr", {16'd0, dn_addr}, {16'd0, a});
            chk("R3 dir", {31'd0, dn_write}, {31'd0, is_wr});
            chk("R3 wdata", {16'd0, dn_wdata}, {16'd0, d});
            repeat (i % 3) tick();
            chk("R3 req held", {15'd0, dn_req, dn_addr}, {15'd0, 1'b1, a});
            if (i % 4 == 2) begin
                wr_reg(3'd3, 32'd1);
                rd_reg(3'd4, v); chk("R8 release in issue", v, stat(1, err_exp));
            end
            if (i == 5) begin
                wr_reg(3'd0, {2'b0, 1'b1, 13'd0, ~a});
                err_exp = 1;
                rd_reg(3'd4, v); chk("R9 busy cmd", v, stat(1, 1));
                chk("R9 addr kept", {16'd0, dn_addr}, {16'd0, a});
                chk("R9 dir kept", {31'd0, dn_write}, {31'd0, is_wr});
            end
            @(negedge clk); dn_ack = 1'b1;
            @(negedge clk); dn_ack = 1'b0;
            if (is_wr) begin
                rd_reg(3'd4, v); chk("R4 idle after write", v, stat(0, err_exp));
                chk("R4 req low", {31'd0, dn_req}, 32'd0);
                rd_reg(3'd2, v); chk("R6 rdata kept", v, {16'd0, last_rd});
            end else begin
                rd_reg(3'd4, v); chk("R5 await", v, stat(2, err_exp));
                if (i % 4 == 0) begin
                    wr_reg(3'd3, 32'd1);
                    rd_reg(3'd4, v); chk("R8 release in await", v, stat(2, err_exp));
                end
                repeat ((i / 2) % 3) tick();
                rd_reg(3'd4, v); chk("R5 still await", v, stat(2, err_exp));
                @(negedge clk); dn_rdata = ~d; dn_rvalid = 1'b1;
                @(negedge clk); dn_rvalid = 1'b0; dn_rdata = 16'hdead;
                last_rd = ~d;
                rd_reg(3'd4, v); chk("R5 hold", v, stat(3, err_exp));
                rd_reg(3'd2, v); chk("R5 capture", v, {16'd0, ~d});
                tick(); dn_rdata = 16'hbeef;
                rd_reg(3'd2, v); chk("R6 stable", v, {16'd0, ~d});
                wr_reg(3'd3, 32'hfffe);
                rd_reg(3'd4, v); chk("R7 bit0 clear ignored", v, stat(3, err_exp));
                if (i == 8) begin
                    wr_reg(3'd0, {2'b0, 1'b1, 13'd0, 16'h0bad});
                    rd_reg(3'd4, v); chk("R9 cmd in hold", v, stat(3, 1));
                    chk("R9 addr in hold", {16'd0, dn_addr}, {16'd0, a});
                end
                wr_reg(3'd3, 32'd1);
                rd_reg(3'd4, v); chk("R7 released", v, stat(0, err_exp));
                rd_reg(3'd2, v); chk("R6 after release", v, {16'd0, ~d});
            end
        end
        rd_reg(3'd5, v); chk("R2 ready held", v, 32'd1);
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
        rd_reg(3'd4, v); chk("R9 err cleared by reset", v, 32'd0);
        rd_reg(3'd2, v); chk("R1 rdata after reset", v, 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule